// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

The block interprets the bus writes that a host issues to a NOR-style parallel flash and turns them into read-mode changes and embedded operations on a small internal word array. Each write strobe carries an address and a data word. The low data byte is the command code. Multi-write unlock sequences select one of six activities: reading the array, reading identification codes, reading a 16-word secured region, a standard word program, the unlock-bypass program mode, and a chip erase. Programs and erases run for a parameterised number of clock cycles. During that time `busy` is high, every write is ignored, and reads return a status word.

The sequencer is a single state machine with 18 named states:
- Read path: `ST_READ` moves to `ST_UNL1` on the first unlock write, and `ST_UNL1` moves to `ST_UNL2` on the second. `ST_UNL2` dispatches on the third write, to `ST_PGM_SET` (A0h), `ST_BYP` (20h), `ST_AUTO` (90h), `ST_SEC` (88h) or `ST_ERS_SET` (80h). Any mismatch at any step goes back to `ST_READ`.
- Standard program: `ST_PGM_SET` takes the address/data write and enters `ST_PGM_BUSY`, which returns to `ST_READ` when the operation completes.
- Unlock bypass: `ST_BYP` moves to `ST_BYP_SET` on A0h, then `ST_BYP_SET` enters `ST_BYP_BUSY` on the address/data write, and `ST_BYP_BUSY` returns to `ST_BYP`. From `ST_BYP`, 90h moves to `ST_BYP_EXIT`. There, 00h leaves for `ST_READ` and anything else falls back to `ST_BYP`.
- Chip erase: `ST_ERS_SET`, `ST_ERS_U1` and `ST_ERS_U2` collect the second unlock pair and the 10h confirm, then `ST_ERS_BUSY` runs the erase and returns to `ST_READ`.
- Identification: `ST_AUTO` returns to `ST_READ` on F0h.
- Secured region: `ST_SEC` walks `ST_SEC_U1`, `ST_SEC_U2` and `ST_SEC_EXIT` on the exit sequence. A mismatch at any step drops back to `ST_SEC`.

The active-low reset is asynchronous. It aborts any operation and forces `ST_READ`. Array contents survive reset, so a host typically erases the chip once after power-up before relying on stored data.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, `busy` is 0 and `rd_data` is 0.
- R2: The unlock pair is data AAh at address 555h, then data 55h at address 2AAh. The full address is compared, and the command byte is `wr_data[7:0]`. A write that breaks the sequence returns to read-array mode, so a later program setup/data pair has no effect.
- R3: A standard program is the unlock pair, then A0h at 555h, then a write of the target address and data. `busy` rises after that fourth write and stays high for exactly PGM_CYCLES cycles, and the word then reads back updated.
- R4: A program stores the old word ANDed with the new data: bits can only go from 1 to 0.
- R5: While `busy` is high, every write is ignored, including complete command sequences. Afterwards the mode is read array.
- R6: Reads while busy return a status word. Bit 6 is 0 on the first read of each operation and inverts on every following read. Bit 7 is the inverse of bit 7 of the data being programmed (0 during erase). All other bits are 0.
- R7: The unlock pair followed by 20h at 555h enters bypass mode. In bypass mode, A0h followed by an address/data write programs a word (busy for PGM_CYCLES), and the pair can be repeated.
- R8: In bypass mode, writes other than A0h and 90h are ignored and bypass mode is kept.
- R9: In bypass mode, 90h then 00h returns to read-array mode. 90h followed by any other code returns to bypass mode.
- R10: The unlock pair followed by 90h at 555h enters identification mode. Reads at address 0 return MFR_ID (default 0001h), at address 1 DEV_ID (default 2250h), and 0 elsewhere. F0h returns to read-array mode.
- R11: The unlock pair followed by 88h at 555h enters the secured region. Reads return SEC_TAG OR the low four address bits (default 5A00h | addr[3:0]). Only the unlock pair, 90h at 555h, then 00h leaves it. Any other write keeps the secured region.
- R12: The unlock pair, 80h at 555h, the unlock pair again and 10h at 555h start a chip erase. It is busy for ERS_CYCLES, then every word reads FFFFh.
- R13: Reset during a program leaves the target word unchanged, clears `busy` and forces read-array mode, leaving bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | Embedded program or erase in progress |

## Verification
The properties assume that `wr_en` and `rd_en` are single-cycle pulses sampled on the rising edge, and that program targets fall inside the array. They also assume the host erases the array before relying on its contents. The directed stimulus drives every strobe on the falling edge for exactly one cycle and always addresses words below the array depth. It performs a chip erase before any program. It waits for `busy` to fall before issuing the next intended command, except where a scenario deliberately writes during an operation or pulls reset in the middle of one.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [4:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_SET,
        ST_PGM_BUSY,
        ST_BYP,
        ST_BYP_SET,
        ST_BYP_BUSY,
        ST_BYP_EXIT,
        ST_AUTO,
        ST_ERS_SET,
        ST_ERS_U1,
        ST_ERS_U2,
        ST_ERS_BUSY,
        ST_SEC,
        ST_SEC_U1,
        ST_SEC_U2,
        ST_SEC_EXIT
    } seq_state_t;

    typedef enum logic [1:0] {
        RS_ARRAY,
        RS_STATUS,
        RS_ID,
        RS_SECURE
    } rd_src_t;

    typedef enum logic {
        OP_PROG,
        OP_ERASE
    } op_kind_t;

    localparam logic [11:0] KEY_ADDR_A  = 12'h555;
    localparam logic [11:0] KEY_ADDR_B  = 12'h2AA;

    localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B   = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_BYPASS  = 8'h20;
    localparam logic [7:0]  CMD_IDENT   = 8'h90;
    localparam logic [7:0]  CMD_SECURE  = 8'h88;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;
    localparam logic [7:0]  CMD_LEAVE   = 8'h00;
    localparam logic [7:0]  CMD_RESET   = 8'hF0;

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        cmd,
    input  logic              op_done,
    output logic              op_start,
    output op_kind_t          op_kind,
    output rd_src_t           rd_src
);

    seq_state_t state_q, state_d;
    logic       at_a, at_b;
    logic       key_a, key_b, busy_st;

    assign at_a  = (wr_addr == ADDR_W'(KEY_ADDR_A));
    assign at_b  = (wr_addr == ADDR_W'(KEY_ADDR_B));
    assign key_a = wr_en && at_a && (cmd == CMD_KEY_A);
    assign key_b = wr_en && at_b && (cmd == CMD_KEY_B);
    assign busy_st = (state_q == ST_PGM_BUSY) || (state_q == ST_BYP_BUSY) ||
                     (state_q == ST_ERS_BUSY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ:     if (key_a) state_d = ST_UNL1;
            ST_UNL1:     if (wr_en) state_d = key_b ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
                if (wr_en) begin
                    state_d = ST_READ;
                    if (at_a) begin
                        unique case (cmd)
                            CMD_PROG:   state_d = ST_PGM_SET;
                            CMD_BYPASS: state_d = ST_BYP;
                            CMD_IDENT:  state_d = ST_AUTO;
                            CMD_SECURE: state_d = ST_SEC;
                            CMD_ERASE:  state_d = ST_ERS_SET;
                            default:    state_d = ST_READ;
                        endcase
                    end
                end
            end
            ST_PGM_SET:  if (wr_en) state_d = ST_PGM_BUSY;
            ST_PGM_BUSY: if (op_done) state_d = ST_READ;
            ST_BYP: begin
                if (wr_en && cmd == CMD_PROG)       state_d = ST_BYP_SET;
                else if (wr_en && cmd == CMD_IDENT) state_d = ST_BYP_EXIT;
            end
            ST_BYP_SET:  if (wr_en) state_d = ST_BYP_BUSY;
            ST_BYP_BUSY: if (op_done) state_d = ST_BYP;
            ST_BYP_EXIT: if (wr_en) state_d = (cmd == CMD_LEAVE) ? ST_READ : ST_BYP;
            ST_AUTO:     if (wr_en && cmd == CMD_RESET) state_d = ST_READ;
            ST_ERS_SET:  if (wr_en) state_d = key_a ? ST_ERS_U1 : ST_READ;
            ST_ERS_U1:   if (wr_en) state_d = key_b ? ST_ERS_U2 : ST_READ;
            ST_ERS_U2: begin
                if (wr_en) state_d = (at_a && cmd == CMD_CHIP) ? ST_ERS_BUSY : ST_READ;
            end
            ST_ERS_BUSY: if (op_done) state_d = ST_READ;
            ST_SEC:      if (key_a) state_d = ST_SEC_U1;
            ST_SEC_U1:   if (wr_en) state_d = key_b ? ST_SEC_U2 : ST_SEC;
            ST_SEC_U2: begin
                if (wr_en) state_d = (at_a && cmd == CMD_IDENT) ? ST_SEC_EXIT : ST_SEC;
            end
            ST_SEC_EXIT: if (wr_en) state_d = (cmd == CMD_LEAVE) ? ST_READ : ST_SEC;
            default:     state_d = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        op_start = 1'b0;
        op_kind  = OP_PROG;
        rd_src   = RS_ARRAY;
        unique case (state_q)
            ST_PGM_SET, ST_BYP_SET: op_start = wr_en;
            ST_ERS_U2: begin
                op_start = wr_en && at_a && (cmd == CMD_CHIP);
                op_kind  = OP_ERASE;
            end
            ST_PGM_BUSY, ST_BYP_BUSY, ST_ERS_BUSY: rd_src = RS_STATUS;
            ST_AUTO: rd_src = RS_ID;
            ST_SEC, ST_SEC_U1, ST_SEC_U2, ST_SEC_EXIT: rd_src = RS_SECURE;
            default: rd_src = RS_ARRAY;
        endcase
    end

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_st && !op_done) |=> (state_q == $past(state_q)));

    // R8
    bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYP && wr_en && cmd != CMD_PROG && cmd != CMD_IDENT)
        |=> (state_q == ST_BYP));

endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer
    import nor_seq_pkg::*;
#(
    parameter int PGM_CYCLES = 8,
    parameter int ERS_CYCLES = 20
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_t kind,
    output logic     busy,
    output logic     done
);

    localparam int MAXC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_len;

    assign load_len = (kind == OP_ERASE) ? CW'(ERS_CYCLES) : CW'(PGM_CYCLES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= load_len;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/nor_seq_array.sv
module nor_seq_array
    import nor_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 16,
    parameter int                DEPTH     = 64,
    parameter int                SEC_DEPTH = 16,
    parameter logic [DATA_W-1:0] MFR_ID    = 16'h0001,
    parameter logic [DATA_W-1:0] DEV_ID    = 16'h2250,
    parameter logic [DATA_W-1:0] SEC_TAG   = 16'h5A00,
    localparam int               AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  op_kind_t          op_kind,
    input  logic              op_done,
    input  logic [AW-1:0]     pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  rd_src_t           rd_src,
    output logic [DATA_W-1:0] rd_data
);

    localparam int SW = $clog2(SEC_DEPTH);

    logic [DATA_W-1:0] mem     [DEPTH];
    logic [DATA_W-1:0] sec_rom [SEC_DEPTH];
    logic [AW-1:0]     pend_addr;
    logic [DATA_W-1:0] pend_data;
    op_kind_t          pend_kind;
    logic              toggle_q;
    logic [DATA_W-1:0] status_w, id_w;

    for (genvar g = 0; g < SEC_DEPTH; g++) begin : g_sec
        assign sec_rom[g] = SEC_TAG | DATA_W'(g);
    end

    // pending operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= '0;
            pend_kind <= OP_PROG;
        end else if (op_start) begin
            pend_addr <= pgm_addr;
            pend_data <= pgm_data;
            pend_kind <= op_kind;
        end
    end

    // status toggle bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           toggle_q <= 1'b0;
        else if (op_start)                    toggle_q <= 1'b0;
        else if (rd_en && rd_src == RS_STATUS) toggle_q <= ~toggle_q;
    end

    // storage: contents survive reset
    always_ff @(posedge clk) begin
        if (op_done) begin
            if (pend_kind == OP_ERASE) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            end else begin
                mem[pend_addr] <= mem[pend_addr] & pend_data;
            end
        end
    end

    always_comb begin
        status_w    = '0;
        status_w[7] = (pend_kind == OP_PROG) ? ~pend_data[7] : 1'b0;
        status_w[6] = toggle_q;
        if (rd_addr == '0)                id_w = MFR_ID;
        else if (rd_addr == ADDR_W'(1))   id_w = DEV_ID;
        else                              id_w = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (rd_src)
                RS_ARRAY:  rd_data <= mem[rd_addr[AW-1:0]];
                RS_STATUS: rd_data <= status_w;
                RS_ID:     rd_data <= id_w;
                RS_SECURE: rd_data <= sec_rom[rd_addr[SW-1:0]];
                default:   rd_data <= '0;
            endcase
        end
    end

    // R4
    prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && pend_kind == OP_PROG)
        |=> ((mem[pend_addr] & ~$past(mem[pend_addr])) == '0));

    // R12
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && pend_kind == OP_ERASE)
        |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
    import nor_seq_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 16,
    parameter int                DEPTH      = 64,
    parameter int                SEC_DEPTH  = 16,
    parameter int                PGM_CYCLES = 8,
    parameter int                ERS_CYCLES = 20,
    parameter logic [DATA_W-1:0] MFR_ID     = 16'h0001,
    parameter logic [DATA_W-1:0] DEV_ID     = 16'h2250,
    parameter logic [DATA_W-1:0] SEC_TAG    = 16'h5A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int AW = $clog2(DEPTH);

    logic     op_start, op_done;
    op_kind_t op_kind;
    rd_src_t  rd_src;

    nor_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .cmd      (wr_data[7:0]),
        .op_done  (op_done),
        .op_start (op_start),
        .op_kind  (op_kind),
        .rd_src   (rd_src)
    );

    nor_seq_timer #(.PGM_CYCLES(PGM_CYCLES), .ERS_CYCLES(ERS_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (op_start),
        .kind  (op_kind),
        .busy  (busy),
        .done  (op_done)
    );

    nor_seq_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .SEC_DEPTH (SEC_DEPTH),
        .MFR_ID    (MFR_ID),
        .DEV_ID    (DEV_ID),
        .SEC_TAG   (SEC_TAG)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_done  (op_done),
        .pgm_addr (wr_addr[AW-1:0]),
        .pgm_data (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_src   (rd_src),
        .rd_data  (rd_data)
    );

    // R5
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_start);

    // R6
    status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_src == RS_STATUS));

endmodule

// File: tb/nor_cmd_sequencer_test.sv
module nor_cmd_sequencer_test;

    localparam int PGM_N = 8;
    localparam int ERS_N = 20;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nor_cmd_sequencer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_now(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_erase();
        int n;
        logic [15:0] s0, s1;
        unlock();
        wr(12'h555, 16'h0080);
        unlock();
        wr_now(12'h555, 16'h0010);
        chk("R12 busy start", busy, 1);
        rd(12'h0, s0);
        rd(12'h0, s1);
        chk("R6 erase status first", s0, 16'h0000);
        chk("R6 erase status second", s1, 16'h0040);
        wait_idle(n);
        chk("R12 busy length", n + 2, ERS_N);
        rd_chk("R12 word 0", 12'h0, 16'hFFFF);
        rd_chk("R12 word 5", 12'h5, 16'hFFFF);
        rd_chk("R12 last word", 12'(DEPTH - 1), 16'hFFFF);
    endtask

    task automatic t_program();
        int n;
        logic [15:0] s0, s1;
        unlock();
        wr(12'h555, 16'h00A0);
        wr_now(12'h003, 16'h1234);
        chk("R3 busy start", busy, 1);
        rd(12'h3, s0);
        rd(12'h3, s1);
        chk("R6 program status first", s0, 16'h0080);
        chk("R6 program status second", s1, 16'h00C0);
        wait_idle(n);
        chk("R3 busy length", n + 2, PGM_N);
        rd_chk("R3 programmed word", 12'h3, 16'h1234);
        unlock();
        wr(12'h555, 16'h00A0);
        wr_now(12'h003, 16'hFF00);
        wait_idle(n);
        chk("R4 busy length", n, PGM_N);
        rd_chk("R4 AND result", 12'h3, 16'h1200);
    endtask

    task automatic t_mismatch();
        wr(12'h555, 16'h00AA);
        wr(12'h123, 16'h0055);
        wr(12'h555, 16'h00A0);
        wr(12'h007, 16'h0000);
        chk("R2 no busy", busy, 0);
        rd_chk("R2 word untouched", 12'h7, 16'hFFFF);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h556, 16'h00A0);
        wr(12'h007, 16'h0000);
        chk("R2 third address", busy, 0);
        rd_chk("R2 word still untouched", 12'h7, 16'hFFFF);
    endtask

    task automatic t_ignore_busy();
        int n;
        unlock();
        wr(12'h555, 16'h00A0);
        wr_now(12'h008, 16'h00F0);
        wr_now(12'h555, 16'h00AA);
        wr_now(12'h2AA, 16'h0055);
        wr_now(12'h555, 16'h00A0);
        wr_now(12'h009, 16'h0000);
        wait_idle(n);
        chk("R5 busy length", n + 4, PGM_N);
        rd_chk("R5 target written", 12'h8, 16'h00F0);
        rd_chk("R5 ignored program", 12'h9, 16'hFFFF);
        wr(12'h009, 16'h0000);
        chk("R5 read mode after", busy, 0);
    endtask

    task automatic t_bypass();
        int n;
        unlock();
        wr(12'h555, 16'h0020);
        wr(12'h000, 16'h00A0);
        wr_now(12'h00A, 16'hAAAA);
        wait_idle(n);
        chk("R7 bypass busy length", n, PGM_N);
        wr(12'h000, 16'h00A0);
        wr_now(12'h00B, 16'h5555);
        wait_idle(n);
        rd_chk("R7 first bypass word", 12'hA, 16'hAAAA);
        rd_chk("R7 second bypass word", 12'hB, 16'h5555);
        wr(12'h000, 16'h00F0);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        chk("R8 no busy on ignored", busy, 0);
        wr(12'h000, 16'h00A0);
        wr_now(12'h00C, 16'h0F0F);
        wait_idle(n);
        rd_chk("R8 still bypass", 12'hC, 16'h0F0F);
        wr(12'h000, 16'h0090);
        wr(12'h000, 16'h0012);
        wr(12'h000, 16'h00A0);
        wr_now(12'h00D, 16'h3333);
        wait_idle(n);
        rd_chk("R9 bad exit stays bypass", 12'hD, 16'h3333);
        wr(12'h000, 16'h0090);
        wr(12'h000, 16'h0000);
        wr(12'h000, 16'h00A0);
        wr(12'h00E, 16'h0000);
        chk("R9 exit no busy", busy, 0);
        rd_chk("R9 exited bypass", 12'hE, 16'hFFFF);
    endtask

    task automatic t_ident();
        unlock();
        wr(12'h555, 16'h0090);
        rd_chk("R10 maker code", 12'h0, 16'h0001);
        rd_chk("R10 device code", 12'h1, 16'h2250);
        rd_chk("R10 other code", 12'h2, 16'h0000);
        wr(12'h000, 16'h00F0);
        rd_chk("R10 back to array", 12'h3, 16'h1200);
    endtask

    task automatic t_secure();
        unlock();
        wr(12'h555, 16'h0088);
        rd_chk("R11 secure word 0", 12'h000, 16'h5A00);
        rd_chk("R11 secure word 5", 12'h005, 16'h5A05);
        rd_chk("R11 secure wraps", 12'h013, 16'h5A03);
        wr(12'h000, 16'h00F0);
        unlock();
        wr(12'h555, 16'h0080);
        rd_chk("R11 stays secure", 12'h002, 16'h5A02);
        unlock();
        wr(12'h555, 16'h0090);
        wr(12'h000, 16'h0000);
        rd_chk("R11 exited", 12'h003, 16'h1200);
    endtask

    task automatic t_hw_reset();
        unlock();
        wr(12'h555, 16'h0020);
        wr(12'h000, 16'h00A0);
        wr_now(12'h014, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 busy cleared", busy, 0);
        rd_chk("R13 word unchanged", 12'h014, 16'hFFFF);
        wr(12'h000, 16'h00A0);
        wr(12'h015, 16'h0000);
        chk("R13 no bypass busy", busy, 0);
        rd_chk("R13 bypass left", 12'h015, 16'hFFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_erase();
        t_program();
        t_mismatch();
        t_ignore_busy();
        t_bypass();
        t_ident();
        t_secure();
        t_hw_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule